// File: doc/BRIEF.md
# Posted Interrupt Delivery Engine

This block takes device interrupt requests, each naming a slot in a small internal remapping table, and resolves every request in one cycle. A slot either forwards the interrupt as an ordinary physical interrupt (a destination CPU plus a vector) or hands it to a virtual CPU. In the second case it sets the guest vector's bit in a per-virtual-CPU pending bitmap and decides whether that physical CPU needs a wake-up notification.

Each virtual-CPU record keeps a pending bitmap, a "notification already in flight" flag, a "stay quiet" flag, and the host vector and CPU used for the notification. Host software uses the configuration port for four jobs: fill table slots, retarget or silence a record (for migration or blocking), drain the in-flight flag and bitmap bits (to model guest consumption), and read back a record's state. A request that names a missing slot or a missing record is dropped and flagged.

Top module: `posted_irq_engine`

## Requirements
- R1: A configuration access has priority. While `cfg_valid` is high, `req_ready` is low, no request is consumed and no result appears in the following cycle. While `cfg_valid` is low, `req_ready` is high and one request is consumed per cycle.
- R2: Slot layout written with `cfg_op`=0 is bit 0 present, bit 1 post type, bit 2 urgent, bits 10:3 vector, bits 14:11 target. A present slot with post type clear yields, one cycle after acceptance, a one-cycle `remap_valid` carrying the target as `remap_dest` and the vector as `remap_vec`.
- R3: A present slot with post type set uses its target as the record number and sets that record's bitmap bit for the slot's vector. It never produces `remap_valid`.
- R4: A posted request to a record whose in-flight flag is clear and whose quiet flag is clear pulses `notif_valid` one cycle after acceptance, with the record's host CPU and host vector. It also sets the in-flight flag.
- R5: A posted request to a record whose in-flight flag is already set records its bit and emits no notification.
- R6: A non-urgent posted request to a record whose quiet flag is set records its bit, emits no notification and leaves the in-flight flag clear.
- R7: An urgent slot overrides the quiet flag. It notifies and sets the in-flight flag whenever the in-flight flag was clear.
- R8: A request index of N_ENT or above, a slot not present, or a posted slot whose target is N_DESC or above gives a one-cycle `fault` one cycle after acceptance, and nothing else changes.
- R9: Record operations, with `cfg_idx` as the record number: `cfg_op`=1 writes the quiet flag (bit 0), host vector (bits 8:1) and host CPU (bits 12:9). `cfg_op`=2 clears the in-flight flag. `cfg_op`=3 clears the bitmap bit named by bits 7:0. Each takes effect for the next request.
- R10: `cfg_op`=4 reads a record. One cycle later `cfg_rdata` is {in-flight flag, bitmap bit named by bits 7:0}, or zero for a record number of N_DESC or above. It holds that value until the next read.
- R11: After reset, every slot is absent, every record is zero (bitmap empty, flags clear, host vector and CPU zero) and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Interrupt request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_idx | input | IDX_W | Remapping slot named by the request |
| cfg_valid | input | 1 | Configuration access this cycle |
| cfg_op | input | 3 | Access kind (0 slot write, 1 record control, 2 clear in-flight, 3 clear bitmap bit, 4 read) |
| cfg_idx | input | IDX_W | Slot or record number |
| cfg_data | input | 3+VEC_W+DST_W | Write data or vector operand |
| cfg_rdata | output | 2 | Read result {in-flight, bitmap bit} |
| remap_valid | output | 1 | Remapped interrupt pulse |
| remap_dest | output | DST_W | Physical CPU of the remapped interrupt |
| remap_vec | output | VEC_W | Vector of the remapped interrupt |
| notif_valid | output | 1 | Notification event pulse |
| notif_dest | output | DST_W | Physical CPU receiving the notification |
| notif_vec | output | VEC_W | Host vector of the notification |
| fault | output | 1 | Dropped-request pulse |

## Verification
The bench builds the engine with 12 slots behind a 4-bit index, so indices 12 to 15 fall outside the table. It uses four records behind a 4-bit target field, so targets 4 to 15 name missing records and reach the posted-slot fault. Vectors are a full 8 bits, so the 256-bit bitmap is exercised at both ends. Random vectors are drawn from a small pool so that repeated posts to the same bit, reads of bits set earlier, and in-flight flags that are still set all occur often.

// File: rtl/pie_pkg.sv
package pie_pkg;
   typedef enum logic [2:0] {
      OP_SLOT_WR  = 3'd0,
      OP_REC_CTL  = 3'd1,
      OP_CLR_BUSY = 3'd2,
      OP_CLR_PEND = 3'd3,
      OP_REC_RD   = 3'd4
   } cfg_op_e;
endpackage

// File: rtl/pie_table.sv
module pie_table #(
   parameter int N_ENT = 12,
   parameter int IDX_W = 4,
   parameter int VEC_W = 8,
   parameter int DST_W = 4,
   localparam int EW = 3 + VEC_W + DST_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [EW-1:0]    wr_data,
   input  logic [IDX_W-1:0] lk_idx,
   output logic             lk_hit,
   output logic             lk_post,
   output logic             lk_urg,
   output logic [VEC_W-1:0] lk_vec,
   output logic [DST_W-1:0] lk_dst
);
   logic [EW-1:0] slot_v [N_ENT];
   logic [EW-1:0] sel;

   for (genvar e = 0; e < N_ENT; e++) begin : g_slot
      logic [EW-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (wr_en && wr_idx == IDX_W'(e))
            slot_q <= wr_data;
      end
      assign slot_v[e] = slot_q;
   end

   always_comb begin
      sel = '0;
      for (int e = 0; e < N_ENT; e++)
         if (lk_idx == IDX_W'(e)) sel = slot_v[e];
   end

   assign lk_hit  = sel[0];
   assign lk_post = sel[1];
   assign lk_urg  = sel[2];
   assign lk_vec  = sel[VEC_W+2:3];
   assign lk_dst  = sel[EW-1:VEC_W+3];
endmodule

// File: rtl/pie_desc.sv
module pie_desc #(
   parameter int N_DESC = 4,
   parameter int VEC_W  = 8,
   parameter int DST_W  = 4,
   localparam int DI_W  = $clog2(N_DESC),
   localparam int NVEC  = 1 << VEC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             post_en,
   input  logic [DI_W-1:0]  post_di,
   input  logic [VEC_W-1:0] post_vec,
   input  logic             post_urg,
   output logic             post_notify,
   output logic [VEC_W-1:0] post_nv,
   output logic [DST_W-1:0] post_ndst,
   input  logic             ctl_wr,
   input  logic             busy_clr,
   input  logic             pend_clr,
   input  logic [DI_W-1:0]  cfg_di,
   input  logic             cfg_quiet,
   input  logic [VEC_W-1:0] cfg_nv,
   input  logic [DST_W-1:0] cfg_ndst,
   input  logic [VEC_W-1:0] cfg_vec,
   output logic             rd_busy,
   output logic             rd_pend
);
   logic [N_DESC-1:0] busy_v;
   logic [N_DESC-1:0] notify_v;
   logic [VEC_W-1:0]  nv_v   [N_DESC];
   logic [DST_W-1:0]  ndst_v [N_DESC];
   logic [NVEC-1:0]   pend_v [N_DESC];

   for (genvar d = 0; d < N_DESC; d++) begin : g_rec
      logic [NVEC-1:0]  pend_q;
      logic             busy_q;
      logic             quiet_q;
      logic [VEC_W-1:0] nv_q;
      logic [DST_W-1:0] ndst_q;
      logic             hit_p;
      logic             hit_c;

      assign hit_p       = post_en && (post_di == DI_W'(d));
      assign hit_c       = (cfg_di == DI_W'(d));
      assign notify_v[d] = hit_p && !busy_q && (!quiet_q || post_urg);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q  <= '0;
            busy_q  <= 1'b0;
            quiet_q <= 1'b0;
            nv_q    <= '0;
            ndst_q  <= '0;
         end else begin
            if (hit_p) begin
               pend_q[post_vec] <= 1'b1;
               if (notify_v[d]) busy_q <= 1'b1;
            end
            if (hit_c && ctl_wr) begin
               quiet_q <= cfg_quiet;
               nv_q    <= cfg_nv;
               ndst_q  <= cfg_ndst;
            end
            if (hit_c && busy_clr) busy_q <= 1'b0;
            if (hit_c && pend_clr) pend_q[cfg_vec] <= 1'b0;
         end
      end

      assign busy_v[d] = busy_q;
      assign nv_v[d]   = nv_q;
      assign ndst_v[d] = ndst_q;
      assign pend_v[d] = pend_q;
   end

   assign post_notify = |notify_v;
   assign post_nv     = nv_v[post_di];
   assign post_ndst   = ndst_v[post_di];
   assign rd_busy     = busy_v[cfg_di];
   assign rd_pend     = pend_v[cfg_di][cfg_vec];
endmodule

// File: rtl/posted_irq_engine.sv
module posted_irq_engine #(
   parameter int N_ENT  = 12,
   parameter int IDX_W  = 4,
   parameter int N_DESC = 4,
   parameter int VEC_W  = 8,
   parameter int DST_W  = 4,
   localparam int CFG_W = 3 + VEC_W + DST_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [IDX_W-1:0] req_idx,
   input  logic             cfg_valid,
   input  logic [2:0]       cfg_op,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic [CFG_W-1:0] cfg_data,
   output logic [1:0]       cfg_rdata,
   output logic             remap_valid,
   output logic [DST_W-1:0] remap_dest,
   output logic [VEC_W-1:0] remap_vec,
   output logic             notif_valid,
   output logic [DST_W-1:0] notif_dest,
   output logic [VEC_W-1:0] notif_vec,
   output logic             fault
);
   import pie_pkg::*;

   localparam int DI_W = $clog2(N_DESC);

   if (N_ENT < 1 || N_ENT > (1 << IDX_W)) begin : g_bad_ent
      $error("N_ENT must fit the request index");
   end
   if (N_DESC < 2 || N_DESC > (1 << DST_W) || N_DESC > (1 << IDX_W)) begin : g_bad_desc
      $error("N_DESC must be at least 2 and fit the target and index fields");
   end
   if (VEC_W < 1 || VEC_W > 8) begin : g_bad_vec
      $error("VEC_W out of range");
   end

   cfg_op_e          op;
   logic             accept;
   logic             lk_hit, lk_post, lk_urg;
   logic [VEC_W-1:0] lk_vec;
   logic [DST_W-1:0] lk_dst;
   logic             rec_ok, crec_ok;
   logic             do_remap, do_post, do_fault;
   logic             post_notify;
   logic [VEC_W-1:0] post_nv;
   logic [DST_W-1:0] post_ndst;
   logic             rd_busy, rd_pend;

   assign op        = cfg_op_e'(cfg_op);
   assign req_ready = !cfg_valid;
   assign accept    = req_valid && req_ready;

   pie_table #(
      .N_ENT (N_ENT),
      .IDX_W (IDX_W),
      .VEC_W (VEC_W),
      .DST_W (DST_W)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_valid && op == OP_SLOT_WR),
      .wr_idx  (cfg_idx),
      .wr_data (cfg_data),
      .lk_idx  (req_idx),
      .lk_hit  (lk_hit),
      .lk_post (lk_post),
      .lk_urg  (lk_urg),
      .lk_vec  (lk_vec),
      .lk_dst  (lk_dst)
   );

   assign rec_ok   = int'(lk_dst) < N_DESC;
   assign crec_ok  = int'(cfg_idx) < N_DESC;
   assign do_remap = accept && lk_hit && !lk_post;
   assign do_post  = accept && lk_hit && lk_post && rec_ok;
   assign do_fault = accept && !(do_remap || do_post);

   pie_desc #(
      .N_DESC (N_DESC),
      .VEC_W  (VEC_W),
      .DST_W  (DST_W)
   ) u_desc (
      .clk         (clk),
      .rst_n       (rst_n),
      .post_en     (do_post),
      .post_di     (lk_dst[DI_W-1:0]),
      .post_vec    (lk_vec),
      .post_urg    (lk_urg),
      .post_notify (post_notify),
      .post_nv     (post_nv),
      .post_ndst   (post_ndst),
      .ctl_wr      (cfg_valid && crec_ok && op == OP_REC_CTL),
      .busy_clr    (cfg_valid && crec_ok && op == OP_CLR_BUSY),
      .pend_clr    (cfg_valid && crec_ok && op == OP_CLR_PEND),
      .cfg_di      (cfg_idx[DI_W-1:0]),
      .cfg_quiet   (cfg_data[0]),
      .cfg_nv      (cfg_data[VEC_W:1]),
      .cfg_ndst    (cfg_data[VEC_W+DST_W:VEC_W+1]),
      .cfg_vec     (cfg_data[VEC_W-1:0]),
      .rd_busy     (rd_busy),
      .rd_pend     (rd_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remap_valid <= 1'b0;
         remap_dest  <= '0;
         remap_vec   <= '0;
         notif_valid <= 1'b0;
         notif_dest  <= '0;
         notif_vec   <= '0;
         fault       <= 1'b0;
         cfg_rdata   <= '0;
      end else begin
         remap_valid <= do_remap;
         notif_valid <= do_post && post_notify;
         fault       <= do_fault;
         if (do_remap) begin
            remap_dest <= lk_dst;
            remap_vec  <= lk_vec;
         end
         if (do_post && post_notify) begin
            notif_dest <= post_ndst;
            notif_vec  <= post_nv;
         end
         if (cfg_valid && op == OP_REC_RD)
            cfg_rdata <= crec_ok ? {rd_busy, rd_pend} : 2'b00;
      end
   end
endmodule

// File: rtl/pie_chk.sv
module pie_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic cfg_valid,
   input logic remap_valid,
   input logic notif_valid,
   input logic fault
);
   a_r1_cfg_blocks_results: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_valid) |-> !(remap_valid || notif_valid || fault));

   a_r2_remap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      remap_valid |-> $past(req_valid && req_ready));

   a_r4_notif_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      notif_valid |-> $past(req_valid && req_ready));

   a_r8_fault_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(req_valid && req_ready));

   a_r3_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({remap_valid, notif_valid, fault}));
endmodule

bind posted_irq_engine pie_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .cfg_valid   (cfg_valid),
   .remap_valid (remap_valid),
   .notif_valid (notif_valid),
   .fault       (fault)
);

// File: tb/sim_posted_irq_engine.sv
`timescale 1ns/1ps
module sim_posted_irq_engine;
   localparam int N_ENT  = 12;
   localparam int IDX_W  = 4;
   localparam int N_DESC = 4;
   localparam int VEC_W  = 8;
   localparam int DST_W  = 4;
   localparam int CFG_W  = 3 + VEC_W + DST_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [IDX_W-1:0] req_idx = '0;
   logic             cfg_valid = 1'b0;
   logic [2:0]       cfg_op = '0;
   logic [IDX_W-1:0] cfg_idx = '0;
   logic [CFG_W-1:0] cfg_data = '0;
   logic [1:0]       cfg_rdata;
   logic             remap_valid, notif_valid, fault;
   logic [DST_W-1:0] remap_dest, notif_dest;
   logic [VEC_W-1:0] remap_vec, notif_vec;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   posted_irq_engine #(
      .N_ENT(N_ENT), .IDX_W(IDX_W), .N_DESC(N_DESC), .VEC_W(VEC_W), .DST_W(DST_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_idx(req_idx), .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .cfg_rdata(cfg_rdata), .remap_valid(remap_valid),
      .remap_dest(remap_dest), .remap_vec(remap_vec), .notif_valid(notif_valid),
      .notif_dest(notif_dest), .notif_vec(notif_vec), .fault(fault)
   );

   // reference model
   logic             m_pres [N_ENT];
   logic             m_post [N_ENT];
   logic             m_urg  [N_ENT];
   logic [VEC_W-1:0] m_vec  [N_ENT];
   logic [DST_W-1:0] m_dst  [N_ENT];
   logic [255:0]     m_pend [N_DESC];
   logic             m_busy [N_DESC];
   logic             m_quiet[N_DESC];
   logic [VEC_W-1:0] m_nv   [N_DESC];
   logic [DST_W-1:0] m_ndst [N_DESC];

   function automatic logic want_notify(logic busy, logic quiet, logic urg);
      return !busy && (!quiet || urg);
   endfunction

   function automatic logic [CFG_W-1:0] slot_word(logic pres, logic post, logic urg,
                                                  logic [VEC_W-1:0] v, logic [DST_W-1:0] t);
      return {t, v, urg, post, pres};
   endfunction

   function automatic logic [CFG_W-1:0] ctl_word(logic quiet, logic [VEC_W-1:0] nv,
                                                 logic [DST_W-1:0] nd);
      return CFG_W'({nd, nv, quiet});
   endfunction

   function automatic logic [26:0] pack_out(logic rv, logic [3:0] rd, logic [7:0] rvec,
                                            logic nvl, logic [3:0] nd, logic [7:0] nvec, logic f);
      return {rv, rv ? {rd, rvec} : 12'h0, nvl, nvl ? {nd, nvec} : 12'h0, f};
   endfunction

   task automatic check(input logic ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_outs(input string tag, input logic [26:0] exp);
      logic [26:0] act;
      act = pack_out(remap_valid, remap_dest, remap_vec, notif_valid, notif_dest, notif_vec, fault);
      check(act == exp, tag, 64'(act), 64'(exp));
   endtask

   task automatic do_req(input int idx);
      logic [26:0] exp;
      string tag;
      int di;
      exp = '0;
      if (idx >= N_ENT || !m_pres[idx]) begin
         exp[0] = 1'b1; tag = "R8 slot";
      end else if (!m_post[idx]) begin
         exp = pack_out(1'b1, m_dst[idx], m_vec[idx], 1'b0, 4'h0, 8'h0, 1'b0);
         tag = "R2 remap";
      end else if (int'(m_dst[idx]) >= N_DESC) begin
         exp[0] = 1'b1; tag = "R8 record";
      end else begin
         di = int'(m_dst[idx]);
         m_pend[di][m_vec[idx]] = 1'b1;
         if (want_notify(m_busy[di], m_quiet[di], m_urg[idx])) begin
            exp = pack_out(1'b0, 4'h0, 8'h0, 1'b1, m_ndst[di], m_nv[di], 1'b0);
            m_busy[di] = 1'b1;
            tag = (m_quiet[di]) ? "R7 urgent" : "R4 notify";
         end else begin
            tag = m_busy[di] ? "R5 busy" : "R6 quiet";
         end
      end
      req_valid = 1'b1;
      req_idx   = IDX_W'(idx);
      cfg_valid = 1'b0;
      #1;
      check(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      check_outs(tag, exp);
   endtask

   task automatic do_cfg(input int op, input int idx, input logic [CFG_W-1:0] data,
                         input logic with_req, input int ridx);
      logic [1:0] exp_rd;
      cfg_valid = 1'b1;
      cfg_op    = 3'(op);
      cfg_idx   = IDX_W'(idx);
      cfg_data  = data;
      req_valid = with_req;
      req_idx   = IDX_W'(ridx);
      #1;
      check(req_ready == 1'b0, "R1 priority", 64'(req_ready), 64'd0);
      exp_rd = 2'b00;
      if (idx < N_DESC) exp_rd = {m_busy[idx], m_pend[idx][data[7:0]]};
      @(negedge clk);
      cfg_valid = 1'b0;
      req_valid = 1'b0;
      check_outs("R1 no result", '0);
      if (op == 4) check(cfg_rdata == exp_rd, "R10 read", 64'(cfg_rdata), 64'(exp_rd));
      case (op)
         0: if (idx < N_ENT) begin
               m_pres[idx] = data[0]; m_post[idx] = data[1]; m_urg[idx] = data[2];
               m_vec[idx] = data[10:3]; m_dst[idx] = data[14:11];
            end
         1: if (idx < N_DESC) begin
               m_quiet[idx] = data[0]; m_nv[idx] = data[8:1]; m_ndst[idx] = data[12:9];
            end
         2: if (idx < N_DESC) m_busy[idx] = 1'b0;
         3: if (idx < N_DESC) m_pend[idx][data[7:0]] = 1'b0;
         default: ;
      endcase
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5A17));
      for (int e = 0; e < N_ENT; e++) begin
         m_pres[e] = 0; m_post[e] = 0; m_urg[e] = 0; m_vec[e] = 0; m_dst[e] = 0;
      end
      for (int d = 0; d < N_DESC; d++) begin
         m_pend[d] = '0; m_busy[d] = 0; m_quiet[d] = 0; m_nv[d] = 0; m_ndst[d] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      check(req_ready == 1'b1, "R11 ready", 64'(req_ready), 64'd1);
      check_outs("R11 outputs", '0);
      check(cfg_rdata == 2'b00, "R11 rdata", 64'(cfg_rdata), 64'd0);
      @(negedge clk);
      do_req(0);                                   // R11 absent slot faults
      do_cfg(4, 0, CFG_W'(0), 1'b0, 0);            // R11 record empty
      do_cfg(4, 3, CFG_W'(255), 1'b0, 0);

      // R2 remap
      do_cfg(0, 0, slot_word(1, 0, 0, 8'h41, 4'd5), 1'b0, 0);
      do_req(0);
      // R3/R4 post and notify
      do_cfg(1, 1, ctl_word(1'b0, 8'hF2, 4'd3), 1'b0, 0);
      do_cfg(0, 1, slot_word(1, 1, 0, 8'h80, 4'd1), 1'b0, 0);
      do_req(1);
      do_cfg(4, 1, CFG_W'(8'h80), 1'b0, 0);         // R3 bit set, busy set
      do_req(1);                                   // R5 no second notification
      // R9 drain and retarget
      do_cfg(2, 1, CFG_W'(0), 1'b0, 0);
      do_cfg(3, 1, CFG_W'(8'h80), 1'b0, 0);
      do_cfg(4, 1, CFG_W'(8'h80), 1'b0, 0);
      do_cfg(1, 1, ctl_word(1'b0, 8'h33, 4'd9), 1'b0, 0);
      do_req(1);                                   // R9 new target used
      // R6 quiet, R7 urgent
      do_cfg(1, 2, ctl_word(1'b1, 8'h20, 4'd2), 1'b0, 0);
      do_cfg(0, 2, slot_word(1, 1, 0, 8'h07, 4'd2), 1'b0, 0);
      do_req(2);
      do_cfg(4, 2, CFG_W'(8'h07), 1'b0, 0);
      do_cfg(0, 3, slot_word(1, 1, 1, 8'hFF, 4'd2), 1'b0, 0);
      do_req(3);
      do_req(3);
      do_cfg(4, 2, CFG_W'(8'hFF), 1'b0, 0);
      // R8 faults
      do_req(15);
      do_req(12);
      do_cfg(0, 5, slot_word(1, 1, 0, 8'h00, 4'd6), 1'b0, 0);
      do_req(5);
      do_cfg(0, 4, slot_word(0, 0, 0, 8'h11, 4'd1), 1'b0, 0);
      do_req(4);
      do_cfg(4, 1, CFG_W'(8'h00), 1'b0, 0);         // R8 record 1 bit 0 untouched
      do_cfg(4, 9, CFG_W'(8'h00), 1'b0, 0);         // R10 missing record reads zero
      // R1 collision
      do_cfg(2, 2, CFG_W'(0), 1'b1, 0);
      do_req(0);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         int k;
         k = int'($urandom % 10);
         if (k < 5) begin
            do_req(int'($urandom % 16));
         end else if (k == 5) begin
            do_cfg(0, int'($urandom % 16),
                   slot_word(($urandom % 8) != 0, $urandom % 2, ($urandom % 4) == 0,
                             8'($urandom % 16), 4'($urandom % 5)),
                   ($urandom % 4) == 0, int'($urandom % 16));
         end else if (k == 6) begin
            do_cfg(1, int'($urandom % 5),
                   ctl_word(($urandom % 3) == 0, 8'($urandom), 4'($urandom)), 1'b0, 0);
         end else if (k == 7) begin
            do_cfg(2, int'($urandom % 5), CFG_W'(0), ($urandom % 4) == 0, int'($urandom % 16));
         end else if (k == 8) begin
            do_cfg(3, int'($urandom % 5), CFG_W'($urandom % 16), 1'b0, 0);
         end else begin
            do_cfg(4, int'($urandom % 5), CFG_W'($urandom % 16), 1'b0, 0);
         end
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule